// File: doc/BRIEF.md
# Reset Jump Boot Controller

This block steers a processor to a boot region in the upper half of memory without loading any vector. When the processor is reset with the jump enable held low, the block arms a flag. While that flag is set, every memory read returns an all-zero opcode, which the processor treats as a no-operation. The program counter therefore walks upward through memory until it reaches the selected region.

The boot region is picked by an eight-bit one-hot select. Each position names one 4K boundary between 0x8000 and 0xF000. The first read inside the 1K window at that boundary raises the ROM select and disarms the flag. From that read onward, memory contents reach the processor unchanged.

An option input states whether an on-board ROM is fitted. If it is, the system-bus data input is disabled while the window is addressed, so the ROM and the bus never drive at the same time. If it is not, the bus input stays enabled, and system memory at the boot address remains visible. A select with no bits set, or with more than one bit set, is flagged as a configuration error and never arms the jump.

Top module: `boot_redirect`

## Requirements
- R1: While reset (rst_n low) is sampled on a rising edge with jump_en_n low and exactly one region_sel bit set, the flag is armed. From the next cycle, a memory read (mreq=1, rd=1, iorq=0) outside the boot window returns cpu_data=0x00 whatever sys_data holds. This applies even while reset is still held, so a stopped processor reading 0x0000 sees 0x00.
- R2: If jump_en_n is high when reset is sampled, the flag is not armed, and every read returns cpu_data=sys_data.
- R3: Zero-forcing applies only to memory reads. In I/O cycles (iorq=1), in interrupt acknowledge cycles (iorq=1, rd=0) and in writes (rd=0), cpu_data equals sys_data, even when the flag is armed.
- R4: region_sel bit k (bit 0 = position 1) selects the boundary 0xF000 - k*0x1000: bit 7 selects 0x8000 and bit 0 selects 0xF000. rom_sel is combinational and is 1 exactly when the select is valid, mreq=1, rd=1, iorq=0, addr[15:12] equals the selected boundary's top nibble and addr[11:10]=0.
- R5: The window is 1K long. Addresses at boundary+0x400 and above do not raise rom_sel, and neither do addresses at boundary-1 and below.
- R6: In a cycle where rom_sel=1, cpu_data equals sys_data. The flag clears at the end of that cycle, and all later reads return sys_data.
- R7: bus_in_dis = 1 exactly when rom_sel = 1 and rom_fitted = 1.
- R8: cfg_err = 1 whenever region_sel does not have exactly one bit set. In that case, rom_sel stays 0 and the jump is never armed.
- R9: The flag is sampled only during reset. Changing jump_en_n after reset has no effect on cpu_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset; samples the jump enable |
| jump_en_n | input | 1 | Active-low jump enable |
| addr | input | 16 | Processor address bus |
| mreq | input | 1 | Memory request, active high |
| rd | input | 1 | Read strobe, active high |
| iorq | input | 1 | I/O request, active high (also set in interrupt acknowledge) |
| sys_data | input | 8 | Data from the system bus |
| region_sel | input | 8 | One-hot boot region select |
| rom_fitted | input | 1 | 1 when an on-board ROM occupies the window |
| cpu_data | output | 8 | Data presented to the processor |
| rom_sel | output | 1 | Boot window / ROM select |
| bus_in_dis | output | 1 | Disable for the system-bus data input |
| cfg_err | output | 1 | Region select is not one-hot |

## Verification
cpu_data, rom_sel, bus_in_dis and cfg_err are combinational from the inputs and the flag. They are due in the same cycle as the bus state that produces them, so the bench samples them two nanoseconds after driving inputs on the falling edge. The flag is the only register. It changes state one rising edge after the reset sample, or one edge after the ROM select, so its effect on cpu_data is checked from the following cycle on. The reference model updates its own flag only after each rising edge.

// File: rtl/boot_pkg.sv
// Package: shared sizes for the reset jump boot controller.
// Assumes a 16-bit address space split into 4K regions with 1K boot windows.
package boot_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int SEL_W      = 8;
    localparam int REGION_LSB = 12;
    localparam int WIN_LSB    = 10;
endpackage

// File: rtl/region_decoder.sv
// region_decoder: turns the one-hot region select into a validity flag and the
// top-address field of the chosen boundary. Bit k maps to field value
// (all ones - k). Assumes SEL_W <= 2**RW.
module region_decoder #(
    parameter int SEL_W = 8,
    parameter int RW    = 4
) (
    input  logic [SEL_W-1:0] region_sel,
    output logic             sel_valid,
    output logic [RW-1:0]    region_field
);
    logic [RW-1:0] term [SEL_W];

    // Build one masked field value per select bit.
    for (genvar k = 0; k < SEL_W; k++) begin : g_term
        localparam logic [RW-1:0] FIELD_K = RW'((2**RW) - 1 - k);
        assign term[k] = region_sel[k] ? FIELD_K : '0;
    end

    // Combine the terms and judge the one-hot condition.
    always_comb begin
        region_field = '0;
        for (int k = 0; k < SEL_W; k++) begin
            region_field = region_field | term[k];
        end
        sel_valid = ($countones(region_sel) == 1);
    end
endmodule

// File: rtl/rom_window.sv
// rom_window: raises the boot window select on a memory read that falls in the
// 1K window at the selected boundary, and derives the bus input disable.
// Assumes mreq/rd/iorq are active high and stable within a cycle.
module rom_window #(
    parameter int ADDR_W     = 16,
    parameter int REGION_LSB = 12,
    parameter int WIN_LSB    = 10,
    localparam int RW        = ADDR_W - REGION_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq,
    input  logic              rd,
    input  logic              iorq,
    input  logic              sel_valid,
    input  logic [RW-1:0]     region_field,
    input  logic              rom_fitted,
    output logic              rom_sel,
    output logic              bus_in_dis
);
    logic mem_read;
    logic in_region;
    logic in_window;

    // Decode the access type and the window position.
    always_comb begin
        mem_read   = mreq && rd && !iorq;
        in_region  = (addr[ADDR_W-1:REGION_LSB] == region_field);
        in_window  = (addr[REGION_LSB-1:WIN_LSB] == '0);
        rom_sel    = sel_valid && mem_read && in_region && in_window;
        bus_in_dis = rom_sel && rom_fitted;
    end

    // R5: a select only ever comes from a memory read in the low 1K of a region.
    a_r5_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (mreq && rd && !iorq && addr[REGION_LSB-1:WIN_LSB] == '0));
    // R7: the input disable never appears without the window select.
    a_r7_dis_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_in_dis |-> (rom_sel && rom_fitted));
endmodule

// File: rtl/jump_flag.sv
// jump_flag: holds the armed state of the reset jump. It is sampled while reset
// is low and cleared by the first window select. Assumes synchronous reset.
module jump_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic jump_en_n,
    input  logic sel_valid,
    input  logic rom_sel,
    output logic armed
);
    // Arm on reset when enabled with a valid select; disarm on the window hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= !jump_en_n && sel_valid;
        end else if (rom_sel) begin
            armed <= 1'b0;
        end
    end

    // R6: after a window select the flag is down.
    a_r6_clear_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |=> !armed);
    // R9: outside reset the flag can never rise again.
    a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !armed);
endmodule

// File: rtl/boot_redirect.sv
// boot_redirect: top of the reset jump boot controller. It forces zero opcodes
// onto the processor data input while the jump flag is armed, until the first
// read of the selected boot window. Assumes active-high bus strobes.
module boot_redirect #(
    parameter int ADDR_W     = boot_pkg::ADDR_W,
    parameter int DATA_W     = boot_pkg::DATA_W,
    parameter int SEL_W      = boot_pkg::SEL_W,
    parameter int REGION_LSB = boot_pkg::REGION_LSB,
    parameter int WIN_LSB    = boot_pkg::WIN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jump_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq,
    input  logic              rd,
    input  logic              iorq,
    input  logic [DATA_W-1:0] sys_data,
    input  logic [SEL_W-1:0]  region_sel,
    input  logic              rom_fitted,
    output logic [DATA_W-1:0] cpu_data,
    output logic              rom_sel,
    output logic              bus_in_dis,
    output logic              cfg_err
);
    localparam int RW = ADDR_W - REGION_LSB;

    logic          sel_valid;
    logic [RW-1:0] region_field;
    logic          armed;
    logic          force_zero;

    region_decoder #(.SEL_W(SEL_W), .RW(RW)) u_dec (
        .region_sel   (region_sel),
        .sel_valid    (sel_valid),
        .region_field (region_field)
    );

    rom_window #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .WIN_LSB(WIN_LSB)) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .mreq         (mreq),
        .rd           (rd),
        .iorq         (iorq),
        .sel_valid    (sel_valid),
        .region_field (region_field),
        .rom_fitted   (rom_fitted),
        .rom_sel      (rom_sel),
        .bus_in_dis   (bus_in_dis)
    );

    jump_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .jump_en_n (jump_en_n),
        .sel_valid (sel_valid),
        .rom_sel   (rom_sel),
        .armed     (armed)
    );

    // Select zeros for armed memory reads that miss the window; else pass bus data.
    always_comb begin
        force_zero = armed && mreq && rd && !iorq && !rom_sel;
        cpu_data   = force_zero ? '0 : sys_data;
        cfg_err    = !sel_valid;
    end

    // R3: cycles that are not memory reads always see bus data.
    a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !(mreq && rd && !iorq) |-> (cpu_data == sys_data));
    // R8: a malformed select never opens the window.
    a_r8_bad_sel_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(region_sel) != 1) |-> !rom_sel);
endmodule

// File: tb/sim_boot_redirect.sv
// Bench for boot_redirect: a behavioural reference model with a stepping
// program counter, compared on every cycle.
module sim_boot_redirect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jump_en_n = 1'b1;
    logic [15:0] addr = '0;
    logic        mreq = 1'b0, rd = 1'b0, iorq = 1'b0;
    logic [7:0]  sys_data = '0;
    logic [7:0]  region_sel = 8'h80;
    logic        rom_fitted = 1'b0;
    logic [7:0]  cpu_data;
    logic        rom_sel, bus_in_dis, cfg_err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit model_flag = 0;
    bit model_known = 0;

    always #4 clk = ~clk;

    boot_redirect u0 (
        .clk(clk), .rst_n(rst_n), .jump_en_n(jump_en_n), .addr(addr),
        .mreq(mreq), .rd(rd), .iorq(iorq), .sys_data(sys_data),
        .region_sel(region_sel), .rom_fitted(rom_fitted),
        .cpu_data(cpu_data), .rom_sel(rom_sel), .bus_in_dis(bus_in_dis),
        .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (addr=%h)", tag, got, exp, addr);
        end
    endtask

    function automatic bit one_hot(input logic [7:0] s);
        int n = 0;
        for (int i = 0; i < 8; i++) if (s[i]) n++;
        return n == 1;
    endfunction

    function automatic logic [15:0] boot_base(input logic [7:0] s);
        logic [15:0] b = 16'h0000;
        for (int i = 0; i < 8; i++) if (s[i]) b = 16'hF000 - 16'(i * 16'h1000);
        return b;
    endfunction

    // One bus cycle: drive on the falling edge, check, then advance the model.
    task automatic cyc(input logic [15:0] a, input bit mq, input bit r, input bit io,
                       input logic [7:0] d, input string tag);
        bit mem_rd, exp_sel, exp_force, next_flag;
        @(negedge clk);
        addr = a; mreq = mq; rd = r; iorq = io; sys_data = d;
        #2;
        mem_rd    = mq && r && !io;
        exp_sel   = one_hot(region_sel) && mem_rd && (a >= boot_base(region_sel))
                    && (a < boot_base(region_sel) + 16'h0400);
        exp_force = model_flag && mem_rd && !exp_sel;
        if (model_known) begin
            check({tag, " cpu_data"}, int'(cpu_data), exp_force ? 0 : int'(d));
            check("R4 rom_sel", int'(rom_sel), int'(exp_sel));
            check("R7 bus_in_dis", int'(bus_in_dis), int'(exp_sel && rom_fitted));
        end
        check("R8 cfg_err", int'(cfg_err), int'(!one_hot(region_sel)));
        if (!rst_n) next_flag = !jump_en_n && one_hot(region_sel);
        else        next_flag = model_flag && !exp_sel;
        @(posedge clk);
        model_flag  = next_flag;
        model_known = 1;
    endtask

    task automatic do_reset(input bit jen_n, input logic [7:0] sel, input bit fitted);
        @(negedge clk);
        rst_n = 1'b0; jump_en_n = jen_n; region_sel = sel; rom_fitted = fitted;
        cyc(16'h0000, 0, 0, 0, 8'h00, "R1");
        cyc(16'h0000, 0, 0, 0, 8'h11, "R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] pc;
        // Reset state, stopped processor: R1 read of 0x0000 during reset is zero.
        do_reset(0, 8'h80, 0);
        @(negedge clk); rst_n = 1'b0;
        cyc(16'h0000, 1, 1, 0, 8'hC3, "R1 stopped-at-reset");
        @(negedge clk); rst_n = 1'b1;

        // R1 walk from 0 to 0x8000 with mixed non-read cycles (R3).
        pc = 16'h0000;
        while (pc != 16'h8000) begin
            cyc(pc, 1, 1, 0, pc[7:0] ^ 8'h5A | 8'h01, "R1 nop walk");
            if (pc[11:0] == 12'h7FF) begin
                cyc({pc[7:0], pc[7:0]}, 0, 1, 1, 8'h3C, "R3 io read");
                cyc(16'h00FF, 0, 0, 1, 8'hE7, "R3 int ack");
                cyc(pc, 1, 0, 0, 8'h99, "R3 mem write");
            end
            pc++;
        end
        // R6: first window read is visible and disarms; then memory is visible.
        cyc(16'h8000, 1, 1, 0, 8'hF3, "R6 first hit");
        cyc(16'h8001, 1, 1, 0, 8'h31, "R6 after hit");
        cyc(16'h0010, 1, 1, 0, 8'h76, "R6 low memory visible");
        cyc(16'h83FF, 1, 1, 0, 8'h42, "R5 last window byte");
        cyc(16'h8400, 1, 1, 0, 8'h43, "R5 past window");
        cyc(16'h7FFF, 1, 1, 0, 8'h44, "R5 below window");

        // R2: jump disabled at reset, position 1 (0xF000), no ROM fitted (R7).
        do_reset(1, 8'h01, 0);
        cyc(16'h0000, 1, 1, 0, 8'hAA, "R2 visible");
        cyc(16'hF000, 1, 1, 0, 8'hBB, "R2 window no rom");
        cyc(16'hF3FF, 1, 1, 0, 8'hBC, "R4 position 1 top");

        // R8: empty select and double select never arm.
        do_reset(0, 8'h00, 1);
        for (int i = 0; i < 8; i++) cyc(16'h8000 + 16'(i * 16'h1000), 1, 1, 0, 8'h5F, "R8 empty sel");
        do_reset(0, 8'h18, 1);
        cyc(16'h0000, 1, 1, 0, 8'h6E, "R8 double sel");
        cyc(16'hB000, 1, 1, 0, 8'h6F, "R8 double sel window");

        // R9/R7: position 4 (0xC000) with ROM fitted; enable toggled after reset.
        do_reset(0, 8'h08, 1);
        pc = 16'hBFF0;
        while (pc != 16'hC000) begin
            if (pc == 16'hBFF8) begin @(negedge clk); jump_en_n = 1'b1; end
            cyc(pc, 1, 1, 0, 8'hD5, "R9 enable toggled");
            pc++;
        end
        cyc(16'hC000, 1, 1, 0, 8'hC9, "R7 rom fitted hit");
        cyc(16'hC001, 1, 1, 0, 8'hC8, "R6 visible after hit");

        // R4: every position maps to its own boundary.
        for (int k = 0; k < 8; k++) begin
            logic [15:0] b;
            b = 16'hF000 - 16'(k * 16'h1000);
            do_reset(1, 8'(1 << k), k[0]);
            cyc(b, 1, 1, 0, 8'h20, "R4 base");
            cyc(b + 16'h03FF, 1, 1, 0, 8'h21, "R4 window end");
            cyc(b + 16'h0400, 1, 1, 0, 8'h22, "R5 above window");
            cyc(b, 1, 1, 1, 8'h23, "R3 io at base");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule